// File: doc/BRIEF.md
# I2C Receive-Only Slave with Selectable Clock-Stretch Point

This block is the receive side of an I2C slave. It watches the bus through an oversampling synchroniser and finds start, repeated-start and stop conditions. It shifts in an address byte and then data bytes. It acknowledges a matching address. At a point that software selects, it holds SCL low, which stalls the master until software releases the bus with a one-cycle strobe.

The stretch point and the interrupt point are the same event. For data bytes it is either the falling edge of the eighth SCL clock or the falling edge of the ninth SCL clock. Software chooses with `wait_at_ninth`. The block samples that input at the end of each address transfer and keeps the sampled value for the data bytes that follow.

The address byte behaves differently. A matching address always stalls at the ninth falling edge. An address whose top five bits are `11110` (the extension-code prefix) stalls at the eighth falling edge. An address that does not match makes the block leave the bus alone until the next start condition.

The bus lines are open-drain. The block never drives them high: it only asserts `scl_pull_low` and `sda_pull_low`. The system clock must run at least eight times the SCL rate.

Top module: `i2c_rx_slave_wait`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins an address phase. A repeated start in the middle of a transfer abandons that transfer and begins a new address phase: the next eight bits are taken as an address, so they do not stall at the eighth falling edge.
- R2: During an address byte, the block never stalls at the eighth falling edge, whatever `wait_at_ninth` says. When bits [7:1] of the address byte (first bit received is bit 7) equal `own_addr`, the block pulls SDA low for the ninth clock, sets `addr_hit`, and then pulses `irq` and holds SCL low from the ninth falling edge.
- R3: When the address byte neither matches nor carries the extension prefix, the block does not acknowledge, raises no byte interrupt and does not hold SCL. It stays this way for all further bytes until the next start condition.
- R4: When bits [7:3] of the address byte equal `11110`, the block sets `ext_hit`, pulses `irq` and holds SCL low from the eighth falling edge. After release, it drives the ninth clock's SDA according to `ack_en`, and it does not stall at the ninth falling edge.
- R5: With the latched select at 0, a data byte pulses `irq` and holds SCL low at its eighth falling edge, with the byte presented on `rx_byte` (first received bit in bit 7). The acknowledge is applied on the ninth clock after release, and there is no second stall at the ninth falling edge.
- R6: With the latched select at 1, a data byte does not stall at the eighth falling edge. The block drives the ninth clock's SDA per `ack_en`, then pulses `irq` and holds SCL low at the ninth falling edge.
- R7: The block samples `wait_at_ninth` only at the ninth falling edge of an address transfer. A change to it during a data phase has no effect until the next address transfer.
- R8: With `ack_en` at 1, the block keeps SDA low through the ninth clock of a data byte. With `ack_en` at 0, it leaves SDA released (NACK). Outside the window from the eighth to the ninth falling edge, the block never pulls SDA.
- R9: A `wait_release` pulse while SCL is held frees SCL on the next clock. A pulse while SCL is not held has no effect on later bytes.
- R10: A stop condition (SDA rising while SCL is high) returns the block to idle. It pulses `irq` only when `stop_irq_en` is 1.
- R11: While `en` is 0, the block releases both lines within one clock, raises no interrupt and ignores all bus traffic and control inputs.
- R12: After reset, both pull-low outputs and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; 0 forces idle with both lines released |
| wait_at_ninth | input | 1 | Data-byte stretch point: 0 = eighth falling edge, 1 = ninth |
| ack_en | input | 1 | 1 = acknowledge data bytes and extension codes, 0 = NACK |
| stop_irq_en | input | 1 | 1 = pulse irq when a stop condition is detected |
| own_addr | input | 7 | Seven-bit slave address |
| wait_release | input | 1 | One-cycle strobe that frees a held SCL |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull_low | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_pull_low | output | 1 | 1 = pull SDA low (acknowledge) |
| irq | output | 1 | One-cycle interrupt pulse |
| rx_byte | output | 8 | Last byte received, updated at each eighth falling edge |
| addr_hit | output | 1 | Current transfer is addressed to this slave |
| ext_hit | output | 1 | Current address byte carried the extension prefix |

## Verification
The assertions assume the bus is electrically well behaved:
- SCL never falls while the block itself holds it low.
- The master changes SDA only while SCL is low, except to signal a start or a stop.
- Each SCL level lasts many system clocks.

The bench master respects all three. It waits for the real line level to go high after releasing SCL, so stretching is honoured. It holds each SCL phase for sixteen system clocks. It moves SDA only in the low phase, apart from its deliberate start, repeated-start and stop sequences.

// File: rtl/i2c_rx_slave_pkg.sv
package i2c_rx_slave_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } slv_phase_e;

  localparam logic [4:0] EXT_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c_rx_line_sync.sv
module i2c_rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_sh_q, scl_sh_d;
  logic [STAGES:0] sda_sh_q, sda_sh_d;
  logic scl_now, scl_prev, sda_now, sda_prev;

  always_comb begin
    scl_sh_d = {scl_sh_q[STAGES-1:0], scl_in};
    sda_sh_d = {sda_sh_q[STAGES-1:0], sda_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
    end else begin
      scl_sh_q <= scl_sh_d;
      sda_sh_q <= sda_sh_d;
    end
  end

  assign scl_now  = scl_sh_q[STAGES-1];
  assign scl_prev = scl_sh_q[STAGES];
  assign sda_now  = sda_sh_q[STAGES-1];
  assign sda_prev = sda_sh_q[STAGES];

  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/i2c_rx_bit_shift.sv
module i2c_rx_bit_shift #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  output logic [CW-1:0] cnt,
  output logic [DW-1:0] shreg,
  output logic          fall_8th,
  output logic          fall_9th
);
  localparam logic [CW-1:0] CNT_BYTE = CW'(DW);
  localparam logic [CW-1:0] CNT_ACK  = CW'(DW + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          sh_en;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    sh_en = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (scl_rise && (cnt_q <= CNT_BYTE)) begin
      cnt_d = cnt_q + 1'b1;
      sh_en = (cnt_q < CNT_BYTE);
      sh_d  = {sh_q[DW-2:0], sda_s};
    end else if (scl_fall && (cnt_q == CNT_ACK)) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (sh_en) sh_q <= sh_d;
    end
  end

  assign cnt      = cnt_q;
  assign shreg    = sh_q;
  assign fall_8th = scl_fall && !clr && (cnt_q == CNT_BYTE);
  assign fall_9th = scl_fall && !clr && (cnt_q == CNT_ACK);

  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_ACK);
endmodule

// File: rtl/i2c_rx_slave_ctrl.sv
module i2c_rx_slave_ctrl
  import i2c_rx_slave_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wait_at_ninth,
  input  logic          ack_en,
  input  logic          stop_irq_en,
  input  logic [AW-1:0] own_addr,
  input  logic          wait_release,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          fall_8th,
  input  logic          fall_9th,
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] shreg,
  output logic          scl_hold,
  output logic          sda_hold,
  output logic          irq,
  output logic [DW-1:0] rx_byte,
  output logic          addr_hit,
  output logic          ext_hit
);
  slv_phase_e    ph_q, ph_d;
  logic          hold_q, hold_d;
  logic          sdal_q, sdal_d;
  logic          irq_q, irq_d;
  logic          pend_q, pend_d;
  logic          wsel_q, wsel_d;
  logic [DW-1:0] rx_q, rx_d;
  logic          hit_q, hit_d;
  logic          ext_q, ext_d;
  logic          is_match, is_ext, rx_en;

  assign is_match = (shreg[DW-1 -: AW] == own_addr);
  assign is_ext   = (shreg[DW-1 -: 5] == EXT_PREFIX);

  always_comb begin
    ph_d   = ph_q;
    hold_d = hold_q;
    sdal_d = sdal_q;
    irq_d  = 1'b0;
    pend_d = pend_q;
    wsel_d = wsel_q;
    rx_d   = rx_q;
    hit_d  = hit_q;
    ext_d  = ext_q;
    if (!en) begin
      ph_d = PH_IDLE; hold_d = 1'b0; sdal_d = 1'b0; pend_d = 1'b0;
      hit_d = 1'b0; ext_d = 1'b0;
    end else if (start_det) begin
      ph_d = PH_ADDR; hold_d = 1'b0; sdal_d = 1'b0; pend_d = 1'b0;
      hit_d = 1'b0; ext_d = 1'b0;
    end else if (stop_det) begin
      ph_d = PH_IDLE; hold_d = 1'b0; sdal_d = 1'b0; pend_d = 1'b0;
      irq_d = stop_irq_en;
    end else begin
      if (wait_release && hold_q) begin
        hold_d = 1'b0;
        if (pend_q) begin
          sdal_d = ack_en;
          pend_d = 1'b0;
        end
      end
      case (ph_q)
        PH_ADDR: begin
          if (fall_8th) begin
            rx_d = shreg;
            if (is_ext) begin
              ext_d = 1'b1; irq_d = 1'b1; hold_d = 1'b1; pend_d = 1'b1;
            end else if (is_match) begin
              hit_d = 1'b1; sdal_d = 1'b1;
            end else begin
              ph_d = PH_IDLE;
            end
          end else if (fall_9th) begin
            sdal_d = 1'b0;
            wsel_d = wait_at_ninth;
            ph_d   = PH_DATA;
            if (!ext_q) begin
              irq_d = 1'b1; hold_d = 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (fall_8th) begin
            rx_d = shreg;
            if (!wsel_q) begin
              irq_d = 1'b1; hold_d = 1'b1; pend_d = 1'b1;
            end else begin
              sdal_d = ack_en;
            end
          end else if (fall_9th) begin
            sdal_d = 1'b0;
            if (wsel_q) begin
              irq_d = 1'b1; hold_d = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rx_en = (ph_q != PH_IDLE) && fall_8th;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      hold_q <= 1'b0;
      sdal_q <= 1'b0;
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
      wsel_q <= 1'b0;
      rx_q   <= '0;
      hit_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      hold_q <= hold_d;
      sdal_q <= sdal_d;
      irq_q  <= irq_d;
      pend_q <= pend_d;
      wsel_q <= wsel_d;
      if (rx_en) rx_q <= rx_d;
      hit_q  <= hit_d;
      ext_q  <= ext_d;
    end
  end

  assign scl_hold = hold_q;
  assign sda_hold = sdal_q;
  assign irq      = irq_q;
  assign rx_byte  = rx_q;
  assign addr_hit = hit_q;
  assign ext_hit  = ext_q;

  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hold_q && !sdal_q && !irq_q));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wait_release && hold_q) |=> !hold_q);

  p_addr_no_wait8_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start_det && !stop_det && ph_q == PH_ADDR && fall_8th && !is_ext && !hold_q)
      |=> !hold_q);

  p_ext_wait8_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start_det && !stop_det && ph_q == PH_ADDR && fall_8th && is_ext)
      |=> (hold_q && irq_q));

  p_stop_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop_det && !start_det && stop_irq_en) |=> irq_q);

  p_ack_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sdal_q |-> (cnt >= CW'(DW)));
endmodule

// File: rtl/i2c_rx_slave_wait.sv
module i2c_rx_slave_wait #(
  parameter int DW         = 8,
  parameter int AW         = 7,
  parameter int SYNC_STAGE = 2,
  localparam int CW        = $clog2(DW + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wait_at_ninth,
  input  logic          ack_en,
  input  logic          stop_irq_en,
  input  logic [AW-1:0] own_addr,
  input  logic          wait_release,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_pull_low,
  output logic          sda_pull_low,
  output logic          irq,
  output logic [DW-1:0] rx_byte,
  output logic          addr_hit,
  output logic          ext_hit
);
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          fall_8th, fall_9th, bit_clr;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg;

  assign bit_clr = !en || start_det || stop_det;

  i2c_rx_line_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rx_bit_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(bit_clr), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_s(sda_s), .cnt(cnt), .shreg(shreg),
    .fall_8th(fall_8th), .fall_9th(fall_9th)
  );

  i2c_rx_slave_ctrl #(.DW(DW), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .wait_at_ninth(wait_at_ninth),
    .ack_en(ack_en), .stop_irq_en(stop_irq_en), .own_addr(own_addr),
    .wait_release(wait_release), .start_det(start_det), .stop_det(stop_det),
    .fall_8th(fall_8th), .fall_9th(fall_9th), .cnt(cnt), .shreg(shreg),
    .scl_hold(scl_pull_low), .sda_hold(sda_pull_low), .irq(irq),
    .rx_byte(rx_byte), .addr_hit(addr_hit), .ext_hit(ext_hit)
  );
endmodule

// File: tb/i2c_rx_slave_wait_tb.sv
module i2c_rx_slave_wait_tb_top;
  localparam int H = 16;
  localparam int NV = 5;
  // {wait_at_ninth, ack_en, data, hold@8, hold@9, sda_low@9}
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b1},
    {1'b0, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h81, 1'b1, 1'b0, 1'b1}
  };

  logic clk, rst_n, en, wait_at_ninth, ack_en, stop_irq_en, wait_release;
  logic [6:0] own_addr;
  logic scl_m_low, sda_m_low, scl_line, sda_line;
  logic scl_pull_low, sda_pull_low, irq, addr_hit, ext_hit;
  logic [7:0] rx_byte;
  int n_chk, n_fail, irq_cnt, cyc;

  assign scl_line = !(scl_m_low || scl_pull_low);
  assign sda_line = !(sda_m_low || sda_pull_low);

  i2c_rx_slave_wait dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wait_at_ninth(wait_at_ninth),
    .ack_en(ack_en), .stop_irq_en(stop_irq_en), .own_addr(own_addr),
    .wait_release(wait_release), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low), .irq(irq),
    .rx_byte(rx_byte), .addr_hit(addr_hit), .ext_hit(ext_hit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && irq) irq_cnt++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_high();
    while (!scl_line) tick(1);
  endtask

  task automatic m_bit(logic b);
    sda_m_low = !b; tick(H);
    scl_m_low = 1'b0; wait_high(); tick(H);
    scl_m_low = 1'b1; tick(H);
  endtask

  task automatic m_byte(logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_bit(d[i]);
  endtask

  task automatic m_ack(output logic got);
    sda_m_low = 1'b0; tick(H);
    scl_m_low = 1'b0; wait_high(); tick(H/2);
    got = sda_line; tick(H/2);
    scl_m_low = 1'b1; tick(H);
  endtask

  task automatic m_start();
    sda_m_low = 1'b1; tick(H);
    scl_m_low = 1'b1; tick(H);
  endtask

  task automatic m_rstart();
    sda_m_low = 1'b0; tick(H);
    scl_m_low = 1'b0; wait_high(); tick(H);
    sda_m_low = 1'b1; tick(H);
    scl_m_low = 1'b1; tick(H);
  endtask

  task automatic m_stop();
    sda_m_low = 1'b1; tick(H);
    scl_m_low = 1'b0; wait_high(); tick(H);
    sda_m_low = 1'b0; tick(H);
  endtask

  task automatic pulse_rel();
    wait_release = 1'b1; tick(1);
    wait_release = 1'b0; tick(2);
  endtask

  // matching address: ack on ninth clock, stall and irq at ninth fall
  task automatic addr_ok();
    int base;
    logic got;
    base = irq_cnt;
    m_start();
    m_byte(8'h54);
    chk("R2", "no hold at addr 8th", scl_pull_low, 0);
    m_ack(got);
    chk("R2", "addr ack", got, 0);
    chk("R2", "hold at addr 9th", scl_pull_low, 1);
    chk("R2", "addr irq", irq_cnt - base, 1);
    pulse_rel();
    chk("R9", "released", scl_pull_low, 0);
  endtask

  initial begin
    logic got;
    int base;
    n_chk = 0; n_fail = 0; irq_cnt = 0; cyc = 0;
    rst_n = 1'b0; en = 1'b0; wait_at_ninth = 1'b0; ack_en = 1'b1;
    stop_irq_en = 1'b0; wait_release = 1'b0; own_addr = 7'h2A;
    scl_m_low = 1'b0; sda_m_low = 1'b0;
    tick(4);
    chk("R12", "scl pull after reset", scl_pull_low, 0);
    chk("R12", "sda pull after reset", sda_pull_low, 0);
    chk("R12", "irq after reset", irq, 0);
    rst_n = 1'b1; tick(2);
    en = 1'b1; tick(4);

    // table walk: R5, R6, R8
    for (int v = 0; v < NV; v++) begin
      wait_at_ninth = VEC[v][12];
      ack_en = VEC[v][11];
      stop_irq_en = 1'b0;
      addr_ok();
      chk("R2", "addr_hit", addr_hit, 1);
      base = irq_cnt;
      m_byte(VEC[v][10:3]);
      chk("R5/R6", "hold at 8th", scl_pull_low, VEC[v][2]);
      chk("R5/R6", "irq at 8th", irq_cnt - base, VEC[v][2]);
      chk("R5", "rx_byte", rx_byte, VEC[v][10:3]);
      if (VEC[v][2]) pulse_rel();
      m_ack(got);
      chk("R8", "ack level", got, !VEC[v][0]);
      chk("R5/R6", "hold at 9th", scl_pull_low, VEC[v][1]);
      chk("R5/R6", "irq per byte", irq_cnt - base, 1);
      if (VEC[v][1]) pulse_rel();
      chk("R8", "sda released after 9th", sda_pull_low, 0);
      m_stop();
      chk("R10", "no stop irq when disabled", irq_cnt - base, 1);
    end

    // R3: non-matching address ignored until next start; R10 stop irq
    wait_at_ninth = 1'b1; ack_en = 1'b1;
    base = irq_cnt;
    m_start();
    m_byte(8'h20);
    chk("R3", "no hold at 8th", scl_pull_low, 0);
    m_ack(got);
    chk("R3", "no ack", got, 1);
    chk("R3", "no hold", scl_pull_low, 0);
    m_byte(8'h55);
    m_ack(got);
    chk("R3", "data ignored ack", got, 1);
    chk("R3", "data ignored hold", scl_pull_low, 0);
    chk("R3", "no irq", irq_cnt - base, 0);
    stop_irq_en = 1'b1;
    m_stop();
    tick(4);
    chk("R10", "stop irq", irq_cnt - base, 1);
    stop_irq_en = 1'b0;

    // R4: extension prefix
    wait_at_ninth = 1'b1; ack_en = 1'b1;
    base = irq_cnt;
    m_start();
    m_byte(8'hF0);
    chk("R4", "hold at 8th", scl_pull_low, 1);
    chk("R4", "irq at 8th", irq_cnt - base, 1);
    chk("R4", "ext_hit", ext_hit, 1);
    pulse_rel();
    m_ack(got);
    chk("R4", "ack after release", got, 0);
    chk("R4", "no hold at 9th", scl_pull_low, 0);
    chk("R4", "single irq", irq_cnt - base, 1);
    m_stop();

    // R7 and R9: select latched at address end; stray strobe harmless
    wait_at_ninth = 1'b1; ack_en = 1'b1;
    addr_ok();
    wait_at_ninth = 1'b0;
    pulse_rel();
    chk("R9", "stray strobe", scl_pull_low, 0);
    base = irq_cnt;
    m_byte(8'h5A);
    chk("R7", "no hold at 8th", scl_pull_low, 0);
    m_ack(got);
    chk("R7", "ack", got, 0);
    chk("R7", "hold at 9th", scl_pull_low, 1);
    chk("R7", "irq", irq_cnt - base, 1);
    pulse_rel();
    m_stop();

    // R1: repeated start restarts the address phase
    wait_at_ninth = 1'b0;
    addr_ok();
    m_rstart();
    m_byte(8'h54);
    chk("R1", "restart: no 8th hold", scl_pull_low, 0);
    m_ack(got);
    chk("R1", "restart: addr ack", got, 0);
    chk("R1", "restart: 9th hold", scl_pull_low, 1);
    pulse_rel();
    m_stop();

    // R11: disable while holding
    addr_ok();
    base = irq_cnt;
    m_byte(8'h11);
    chk("R11", "holding before disable", scl_pull_low, 1);
    en = 1'b0; tick(1);
    chk("R11", "scl released", scl_pull_low, 0);
    chk("R11", "sda released", sda_pull_low, 0);
    stop_irq_en = 1'b1; ack_en = 1'b1;
    m_ack(got);
    chk("R11", "no ack while off", got, 1);
    m_stop();
    m_start();
    m_byte(8'h54);
    m_ack(got);
    chk("R11", "address ignored while off", got, 1);
    m_stop();
    tick(4);
    chk("R11", "no irq while off", irq_cnt - base, 1);
    en = 1'b1; tick(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule